// File: doc/BRIEF.md
# UART Automatic Modem Flow Control

This block sits between a UART's transmit shifter, its receive FIFO and the modem handshake pins. In the input direction it watches one active-low "clear to send" style line and, when automatic input control is enabled, tells the shifter to stop starting new characters while that line is high. The stop takes effect only between characters, so a character already on the wire always finishes. A single pair-select bit chooses which line is watched: the clear-to-send input or the data-set-ready input.

In the output direction it drives two active-low request pins. When automatic output control is enabled, the pin named by the same pair-select bit is driven from the receive FIFO fill level, with hysteresis. The pin is raised (stop sending to us) once the level reaches an upper threshold and lowered again once it drains to a lower threshold. Any pin that is not under automatic control simply follows a software-written level bit, so each pin doubles as a general-purpose output.

The handshake inputs are asynchronous and pass through a two-flop synchroniser before use. Framing, baud generation and the FIFOs themselves live elsewhere.

Top module: `uart_autoflow`

## Requirements
- R1: While reset is held and on the first cycle after it, `rts_n` and `dtr_n` are 1 and `tx_allowed` is 1, whatever the software bits are.
- R2: A change on `cts_n` or `dsr_n` passes through two synchroniser flops. With `tx_char_busy` low, `tx_allowed` still shows the old value two clock edges after the change and the new value at the third edge.
- R3: With `auto_in_en` = 0, `tx_allowed` is 1 for every combination of `cts_n`, `dsr_n` and `line_sel`.
- R4: With `auto_in_en` = 1 and `line_sel` = 0, `tx_allowed` is the inverse of the synchronised `cts_n`, and `dsr_n` has no effect.
- R5: With `auto_in_en` = 1 and `line_sel` = 1, `tx_allowed` is the inverse of the synchronised `dsr_n`, and `cts_n` has no effect.
- R6: While `tx_char_busy` is 1, `tx_allowed` does not change. A pending halt or resume is applied at the first clock edge on which `tx_char_busy` is 0.
- R7: With `auto_out_en` = 1, a `rx_level` at or above `hi_thresh` drives the selected output pin to 1 two clock edges later.
- R8: With `auto_out_en` = 1, a `rx_level` at or below `lo_thresh` drives the selected pin to 0. A level strictly between the thresholds leaves the pin as it was. The upper threshold has priority if both conditions hold.
- R9: With `auto_out_en` = 0, `rts_n` follows `sw_rts_n` and `dtr_n` follows `sw_dtr_n`, one clock edge later.
- R10: `line_sel` = 0 puts `rts_n` under automatic control and leaves `dtr_n` on `sw_dtr_n`. `line_sel` = 1 puts `dtr_n` under automatic control and leaves `rts_n` on `sw_rts_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_in_en | input | 1 | Enable automatic transmit halting from the handshake input |
| auto_out_en | input | 1 | Enable automatic drive of the request output from the FIFO level |
| line_sel | input | 1 | Pair select: 0 = CTS/RTS pair, 1 = DSR/DTR pair |
| cts_n | input | 1 | Asynchronous clear-to-send input, active low |
| dsr_n | input | 1 | Asynchronous data-set-ready input, active low |
| sw_rts_n | input | 1 | Software level for `rts_n` when it is not automatically driven |
| sw_dtr_n | input | 1 | Software level for `dtr_n` when it is not automatically driven |
| tx_char_busy | input | 1 | High while the shifter is in the middle of a character |
| rx_level | input | LVL_W | Receive FIFO fill count |
| hi_thresh | input | LVL_W | Level at or above which the request is withdrawn |
| lo_thresh | input | LVL_W | Level at or below which the request is reasserted |
| tx_allowed | output | 1 | Shifter may start a new character |
| rts_n | output | 1 | Request-to-send output, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |

## Verification
On every cycle, the assertions check four things: the reset levels, that `tx_allowed` holds during a character, that it stays high while input automation is off, and that the non-automated pins track their software bits. They also check that the selected pin is raised one edge after a level at or above the upper threshold has been registered. Only the bench's scenarios show the rest. These are the exact three-edge synchroniser latency, that the unselected handshake input has no effect, and that the selected pin holds in the band between the thresholds during full rising and falling sweeps of the FIFO level. They also show that the halt and resume are released on the first idle edge after a character.

// File: rtl/uart_autoflow_pkg.sv
// Package: shared types and constants for the automatic modem flow control block.
// Assumes: nothing beyond standard SystemVerilog.
package uart_autoflow_pkg;

    // Which modem line pair takes part in automatic handshaking.
    typedef enum logic {
        PAIR_CTS_RTS = 1'b0,
        PAIR_DSR_DTR = 1'b1
    } pair_sel_e;

    // Idle (deasserted) level of every active-low modem line.
    localparam logic LINE_IDLE = 1'b1;

endpackage

// File: rtl/hs_sync.sv
// Module: hs_sync
// Multi-bit flop-chain synchroniser for independent asynchronous handshake lines.
// Assumes: each bit is an unrelated slow level (no bus coherency needed);
// the chain resets to the idle (high) level of an active-low line.
module hs_sync #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    import uart_autoflow_pkg::*;

    logic [WIDTH-1:0] stage [DEPTH];

    genvar s;
    generate
        for (s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the raw asynchronous levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= {WIDTH{LINE_IDLE}};
                    else        stage[0] <= async_in;
                end
            end else begin : g_next
                // Purpose: let metastability settle through one more flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= {WIDTH{LINE_IDLE}};
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage[DEPTH-1];

endmodule

// File: rtl/tx_gate.sv
// Module: tx_gate
// Produces the registered transmit-allowed flag for the shifter. The flag is
// re-evaluated only while no character is in flight, so a halt never cuts a
// character in half.
// Assumes: halt_req is already synchronous to clk.
module tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic char_busy,
    output logic allowed
);
    // Purpose: update the permission only on character boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)          allowed <= 1'b1;
        else if (!char_busy) allowed <= !halt_req;
    end
endmodule

// File: rtl/rx_hyst.sv
// Module: rx_hyst
// Hysteresis comparator on the receive FIFO level. The stop flag sets at or
// above the upper threshold and clears at or below the lower one; in between
// it holds. The upper threshold wins when both apply.
// Assumes: thresholds are quasi-static software settings.
module rx_hyst #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] hi_th,
    input  logic [LVL_W-1:0] lo_th,
    output logic             stop
);
    logic at_hi;
    logic at_lo;

    // Purpose: compare the level against both thresholds.
    always_comb begin
        at_hi = (level >= hi_th);
        at_lo = (level <= lo_th);
    end

    // Purpose: hold the stop state between the two thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)     stop <= 1'b0;
        else if (at_hi) stop <= 1'b1;
        else if (at_lo) stop <= 1'b0;
    end
endmodule

// File: rtl/pin_drive.sv
// Module: pin_drive
// Registers the two active-low request pins. The pin picked by the pair
// select follows the automatic stop flag when output automation is on;
// every other case falls back to the software-written level.
// Assumes: stop is registered upstream; pins reset to the idle level.
module pin_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic pair_sel,
    input  logic stop,
    input  logic sw_rts_n,
    input  logic sw_dtr_n,
    output logic rts_n,
    output logic dtr_n
);
    import uart_autoflow_pkg::*;

    logic rts_auto;
    logic dtr_auto;
    logic rts_nxt;
    logic dtr_nxt;

    // Purpose: decide which pin is automated and its next level.
    always_comb begin
        rts_auto = auto_en && (pair_sel == PAIR_CTS_RTS);
        dtr_auto = auto_en && (pair_sel == PAIR_DSR_DTR);
        rts_nxt  = rts_auto ? stop : sw_rts_n;
        dtr_nxt  = dtr_auto ? stop : sw_dtr_n;
    end

    // Purpose: register the pins, forcing the idle level in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_n <= LINE_IDLE;
            dtr_n <= LINE_IDLE;
        end else begin
            rts_n <= rts_nxt;
            dtr_n <= dtr_nxt;
        end
    end
endmodule

// File: rtl/uart_autoflow.sv
// Module: uart_autoflow
// Top of the automatic modem flow control block: synchronises the handshake
// inputs, gates the transmitter on character boundaries and drives the
// request pins from the receive FIFO level with hysteresis.
// Assumes: tx_char_busy, rx_level and all control bits are synchronous to clk;
// cts_n and dsr_n may be fully asynchronous.
module uart_autoflow #(
    parameter int LVL_W      = 7,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_in_en,
    input  logic             auto_out_en,
    input  logic             line_sel,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             sw_rts_n,
    input  logic             sw_dtr_n,
    input  logic             tx_char_busy,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] hi_thresh,
    input  logic [LVL_W-1:0] lo_thresh,
    output logic             tx_allowed,
    output logic             rts_n,
    output logic             dtr_n
);
    import uart_autoflow_pkg::*;

    localparam int HS_LINES = 2;

    logic [HS_LINES-1:0] hs_sync_q;
    logic                cts_s;
    logic                dsr_s;
    logic                watched_n;
    logic                halt_req;
    logic                stop_q;

    hs_sync #(
        .WIDTH (HS_LINES),
        .DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dsr_n, cts_n}),
        .sync_out (hs_sync_q)
    );

    // Purpose: pick the watched handshake input and form the halt request.
    always_comb begin
        cts_s     = hs_sync_q[0];
        dsr_s     = hs_sync_q[1];
        watched_n = (line_sel == PAIR_DSR_DTR) ? dsr_s : cts_s;
        halt_req  = auto_in_en && watched_n;
    end

    tx_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_req  (halt_req),
        .char_busy (tx_char_busy),
        .allowed   (tx_allowed)
    );

    rx_hyst #(
        .LVL_W (LVL_W)
    ) u_hyst (
        .clk   (clk),
        .rst_n (rst_n),
        .level (rx_level),
        .hi_th (hi_thresh),
        .lo_th (lo_thresh),
        .stop  (stop_q)
    );

    pin_drive u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_out_en),
        .pair_sel (line_sel),
        .stop     (stop_q),
        .sw_rts_n (sw_rts_n),
        .sw_dtr_n (sw_dtr_n),
        .rts_n    (rts_n),
        .dtr_n    (dtr_n)
    );

endmodule

// File: rtl/uart_autoflow_chk.sv
// Module: uart_autoflow_chk
// Port-level temporal checks on uart_autoflow, attached with bind.
// Assumes: sees exactly the top module's ports.
module uart_autoflow_chk #(
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             auto_in_en,
    input logic             auto_out_en,
    input logic             line_sel,
    input logic             sw_rts_n,
    input logic             sw_dtr_n,
    input logic             tx_char_busy,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] hi_thresh,
    input logic             tx_allowed,
    input logic             rts_n,
    input logic             dtr_n
);
    // R1: first cycle after reset shows idle pins and open transmitter.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rts_n && dtr_n && tx_allowed));

    // R6: permission frozen while a character is in flight.
    assert_hold_in_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tx_char_busy)) |-> $stable(tx_allowed));

    // R3: input automation off and idle shifter means transmission allowed.
    assert_no_halt_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(auto_in_en) && !$past(tx_char_busy)) |-> tx_allowed);

    // R9: output automation off means both pins follow software.
    assert_gpo_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(auto_out_en)) |->
            (rts_n == $past(sw_rts_n) && dtr_n == $past(sw_dtr_n)));

    // R10: the pin outside the selected pair stays on its software bit.
    assert_unselected_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
            ($past(line_sel) ? (rts_n == $past(sw_rts_n)) : (dtr_n == $past(sw_dtr_n))));

    // R7: a level at or above the upper threshold withdraws the selected request.
    assert_hi_withdraw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(auto_out_en)
         && ($past(rx_level, 2) >= $past(hi_thresh, 2)))
        |-> ($past(line_sel) ? dtr_n : rts_n));

endmodule

bind uart_autoflow uart_autoflow_chk #(.LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_in_en   (auto_in_en),
    .auto_out_en  (auto_out_en),
    .line_sel     (line_sel),
    .sw_rts_n     (sw_rts_n),
    .sw_dtr_n     (sw_dtr_n),
    .tx_char_busy (tx_char_busy),
    .rx_level     (rx_level),
    .hi_thresh    (hi_thresh),
    .tx_allowed   (tx_allowed),
    .rts_n        (rts_n),
    .dtr_n        (dtr_n)
);

// File: tb/tb_uart_autoflow.sv
// Bench for uart_autoflow: sweeps handshake combinations and full FIFO
// level ramps, computing expected pin levels arithmetically.
module tb_uart_autoflow;
    localparam int  LVL_W = 7;
    localparam time CLK_P = 8ns;
    localparam int  HI    = 48;
    localparam int  LO    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             auto_in_en = 1'b0;
    logic             auto_out_en = 1'b0;
    logic             line_sel = 1'b0;
    logic             cts_n = 1'b1;
    logic             dsr_n = 1'b1;
    logic             sw_rts_n = 1'b0;
    logic             sw_dtr_n = 1'b0;
    logic             tx_char_busy = 1'b0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] hi_thresh = LVL_W'(HI);
    logic [LVL_W-1:0] lo_thresh = LVL_W'(LO);
    logic             tx_allowed;
    logic             rts_n;
    logic             dtr_n;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    uart_autoflow #(.LVL_W(LVL_W), .SYNC_DEPTH(2)) dut (
        .clk(clk), .rst_n(rst_n), .auto_in_en(auto_in_en), .auto_out_en(auto_out_en),
        .line_sel(line_sel), .cts_n(cts_n), .dsr_n(dsr_n), .sw_rts_n(sw_rts_n),
        .sw_dtr_n(sw_dtr_n), .tx_char_busy(tx_char_busy), .rx_level(rx_level),
        .hi_thresh(hi_thresh), .lo_thresh(lo_thresh), .tx_allowed(tx_allowed),
        .rts_n(rts_n), .dtr_n(dtr_n)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic stop_m;
        // R1: reset forces idle levels even with software bits low.
        @(negedge clk);
        step(2);
        chk("R1", "rts_n in reset", rts_n, 1'b1);
        chk("R1", "dtr_n in reset", dtr_n, 1'b1);
        chk("R1", "tx_allowed in reset", tx_allowed, 1'b1);
        sw_rts_n = 1'b1;
        sw_dtr_n = 1'b1;
        rst_n = 1'b1;
        step(1);
        chk("R1", "rts_n after reset", rts_n, 1'b1);
        chk("R1", "dtr_n after reset", dtr_n, 1'b1);

        // R3 / R4 / R5: all handshake combinations, shifter idle.
        for (int i = 0; i < 16; i++) begin
            logic exp_ok;
            auto_in_en = i[3];
            line_sel   = i[2];
            cts_n      = i[1];
            dsr_n      = i[0];
            step(4);
            exp_ok = !(i[3] && (i[2] ? i[0] : i[1]));
            chk(!i[3] ? "R3" : (i[2] ? "R5" : "R4"), "tx_allowed sweep", tx_allowed, exp_ok);
        end

        // R2: exact synchroniser latency.
        auto_in_en = 1'b1; line_sel = 1'b0; cts_n = 1'b0; dsr_n = 1'b0;
        step(4);
        cts_n = 1'b1;
        step(2);
        chk("R2", "old value after two edges", tx_allowed, 1'b1);
        step(1);
        chk("R2", "new value at third edge", tx_allowed, 1'b0);
        cts_n = 1'b0;
        step(3);
        chk("R2", "resume at third edge", tx_allowed, 1'b1);

        // R6: halt and resume wait for the character boundary.
        tx_char_busy = 1'b1;
        cts_n = 1'b1;
        step(5);
        chk("R6", "halt deferred in char", tx_allowed, 1'b1);
        tx_char_busy = 1'b0;
        step(1);
        chk("R6", "halt on first idle edge", tx_allowed, 1'b0);
        tx_char_busy = 1'b1;
        cts_n = 1'b0;
        step(5);
        chk("R6", "resume deferred in char", tx_allowed, 1'b0);
        tx_char_busy = 1'b0;
        step(1);
        chk("R6", "resume on first idle edge", tx_allowed, 1'b1);

        // R7 / R8 / R10: level ramps on each pair, thresholds 48 and 16.
        auto_out_en = 1'b1;
        stop_m = 1'b0;
        for (int sel = 0; sel < 2; sel++) begin
            line_sel = sel[0];
            sw_rts_n = sel[0] ? 1'b1 : 1'b0;
            sw_dtr_n = sel[0] ? 1'b0 : 1'b1;
            for (int k = 0; k < 130; k++) begin
                int lvl;
                lvl = (k < 65) ? k : 129 - k;
                rx_level = LVL_W'(lvl);
                step(3);
                if (lvl >= HI)      stop_m = 1'b1;
                else if (lvl <= LO) stop_m = 1'b0;
                chk(lvl >= HI ? "R7" : "R8", "auto pin vs level",
                    sel[0] ? dtr_n : rts_n, stop_m);
                chk("R10", "other pin on software bit",
                    sel[0] ? rts_n : dtr_n, sel[0] ? sw_rts_n : sw_dtr_n);
            end
        end

        // R9: automation off, every select and software combination.
        auto_out_en = 1'b0;
        rx_level = LVL_W'(64);
        for (int i = 0; i < 8; i++) begin
            line_sel = i[2];
            sw_rts_n = i[1];
            sw_dtr_n = i[0];
            step(1);
            chk("R9", "rts_n general purpose", rts_n, i[1]);
            chk("R9", "dtr_n general purpose", dtr_n, i[0]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule